// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block drives an external 12-bit successive-approximation converter that sits behind an eight-way analog input multiplexer. One configuration word sets the conversion clock divisor, the number of channels to scan, and where results go. A separate enable bit in the same word starts and stops the scan. While the block is enabled it produces the converter clock, holds the converter in reset when idle, drives the multiplexer select, sends a start strobe, and waits for the converter's done signal. It then captures the result and moves on to the next channel. Channels are visited in ascending order from 0 to N-1, and the scan wraps back to 0 without stopping.

Each result is written as a 32-bit word. In register mode, software reads the latest word for any channel through a read port. In stream mode, words leave on a valid/ready output for a DMA engine. Because the scan always restarts at channel 0, the stream is made of frames that begin at channel 0. A length checker flags a transfer length that does not hold a whole number of frames. If a second result arrives while the single pending stream word is still waiting, the block sets a sticky overflow flag. The recovery sequence is to clear the enable bit, which also clears the flag, and then enable again.

Top module: `adc_scan_seq`

## Requirements
- R1: Configuration word layout: bit 31 = enable, bit 3 = stream mode, bits 2:0 = last channel index (N = value+1), bits 23:16 = clock divisor D. While enable is 0, adc_rst is 1, adc_start is 0 and adc_clk is 0. All fields can be written with enable left at 0.
- R2: adc_clk has a period of exactly 2*(D+1) system clock cycles.
- R3: adc_start stays high for exactly one adc_clk period. It rises and falls in the same cycles in which adc_clk rises.
- R4: adc_sel does not change from the cycle adc_start rises until the converter signals done.
- R5: After enable, the first conversion uses channel 0. Channels follow in ascending order up to N-1 and then wrap to 0.
- R6: Result word format: bits 11:0 hold the 12-bit result, bits 18:16 hold the channel number, and all other bits are 0.
- R7: With stream mode off, each result updates that channel's data register and nothing appears on the stream. rd_data shows the word for rd_chan one cycle after rd_chan is presented.
- R8: With stream mode on, results are offered on dma_valid/dma_data in scan order. The first word after enable is from channel 0. A word is held unchanged while dma_valid=1 and dma_ready=0.
- R9: If a new result arrives while a word is pending and not being accepted in that cycle, the new result is dropped and ovf_flag is set. ovf_flag then stays set.
- R10: A configuration write with enable 0 clears ovf_flag. The next enable restarts the scan at channel 0.
- R11: len_err is 1 when the programmed length (in words) is 0 or is not a multiple of N. Otherwise it is 0. The flag updates within two cycles of a length or configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| len_we | input | 1 | Transfer length write strobe |
| len_words | input | 16 | Transfer length in 32-bit words |
| rd_chan | input | 3 | Channel whose data register is read |
| rd_data | output | 32 | Data register of rd_chan, one cycle later |
| adc_clk | output | 1 | Converter clock |
| adc_rst | output | 1 | Converter reset, high while disabled |
| adc_start | output | 1 | Conversion start strobe |
| adc_sel | output | 3 | Analog multiplexer select |
| adc_done | input | 1 | Converter end of conversion |
| adc_dout | input | 12 | Converter result |
| dma_valid | output | 1 | Stream word valid |
| dma_ready | input | 1 | Stream sink ready |
| dma_data | output | 32 | Stream word |
| ovf_flag | output | 1 | Sticky stream overflow |
| len_err | output | 1 | Transfer length is not a whole number of frames |

## Verification
The assertions assume that adc_done and adc_dout are synchronous to clk and that done is raised only after adc_start has fallen. They also assume that the divisor and channel count change only while enable is 0. The converter model in the bench pulses done a fixed three cycles after start falls and stays silent while the block is disabled. Every reconfiguration is done with enable cleared first. The stream sink drops dma_ready only in the overflow test.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CFG_EN_BIT  = 31;
  localparam int CFG_DMA_BIT = 3;
  localparam int CFG_DIV_LSB = 16;
  localparam int WORD_W      = 32;
  localparam int CHAN_LSB    = 16;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_SETUP,
    ST_START,
    ST_WAIT
  } scan_state_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             adc_clk,
  output logic             rise_next
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             wrap;

  assign wrap      = (cnt_q == div);
  // rise_next marks the edge at which adc_clk goes high
  assign rise_next = run && wrap && !clk_q;
  assign adc_clk   = clk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] last_chan,
  input  logic             rise_next,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_dout,
  output logic             adc_rst,
  output logic             adc_start,
  output logic [SEL_W-1:0] adc_sel,
  output logic             res_valid,
  output logic [SEL_W-1:0] res_chan,
  output logic [RES_W-1:0] res_data
);
  scan_state_t      state_q;
  logic [SEL_W-1:0] next_chan;

  // wrap also covers a count reduced below the current channel
  assign next_chan = (adc_sel >= last_chan) ? '0 : adc_sel + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      adc_rst   <= 1'b1;
      adc_start <= 1'b0;
      adc_sel   <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (!run) begin
        state_q   <= ST_OFF;
        adc_rst   <= 1'b1;
        adc_start <= 1'b0;
        adc_sel   <= '0;
      end else begin
        case (state_q)
          ST_OFF: begin
            adc_rst <= 1'b0;
            state_q <= ST_SETUP;
          end
          ST_SETUP: begin
            if (rise_next) begin
              adc_start <= 1'b1;
              state_q   <= ST_START;
            end
          end
          ST_START: begin
            if (rise_next) begin
              adc_start <= 1'b0;
              state_q   <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (adc_done) begin
              res_valid <= 1'b1;
              res_chan  <= adc_sel;
              res_data  <= adc_dout;
              adc_sel   <= next_chan;
              state_q   <= ST_SETUP;
            end
          end
          default: state_q <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_result_sink.sv
module adc_result_sink
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int SEL_W = 3,
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_mode,
  input  logic              ovf_clr,
  input  logic              res_valid,
  input  logic [SEL_W-1:0]  res_chan,
  input  logic [RES_W-1:0]  res_data,
  input  logic [SEL_W-1:0]  rd_chan,
  output logic [WORD_W-1:0] rd_data,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [WORD_W-1:0] dma_data,
  output logic              ovf_flag
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] mem [NCH];
  logic              slot_free;

  always_comb begin
    word = '0;
    word[RES_W-1:0] = res_data;
    word[CHAN_LSB +: SEL_W] = res_chan;
  end

  // per-channel registers: no reset, read registered
  always_ff @(posedge clk) begin
    if (res_valid && !dma_mode)
      mem[res_chan] <= word;
    rd_data <= mem[rd_chan];
  end

  assign slot_free = !dma_valid || dma_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_valid <= 1'b0;
      dma_data  <= '0;
    end else if (res_valid && dma_mode && slot_free) begin
      dma_valid <= 1'b1;
      dma_data  <= word;
    end else if (dma_valid && dma_ready) begin
      dma_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ovf_clr)
      ovf_flag <= 1'b0;
    else if (res_valid && dma_mode && !slot_free)
      ovf_flag <= 1'b1;
  end
endmodule

// File: rtl/adc_len_check.sv
module adc_len_check #(
  parameter int LEN_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_words,
  input  logic [SEL_W-1:0] last_chan,
  output logic             len_err
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] frame;
  logic [LEN_W-1:0] rem;

  assign frame = LEN_W'(last_chan) + 1'b1;
  assign rem   = len_q % frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      len_err <= 1'b1;
    end else begin
      if (len_we) len_q <= len_words;
      len_err <= (len_q == '0) || (rem != '0);
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 12,
  parameter int DIV_W = 8,
  parameter int LEN_W = 16,
  localparam int SEL_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_words,
  input  logic [SEL_W-1:0]  rd_chan,
  output logic [WORD_W-1:0] rd_data,
  output logic              adc_clk,
  output logic              adc_rst,
  output logic              adc_start,
  output logic [SEL_W-1:0]  adc_sel,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_dout,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [WORD_W-1:0] dma_data,
  output logic              ovf_flag,
  output logic              len_err
);
  logic             en_q;
  logic             dma_q;
  logic [SEL_W-1:0] last_q;
  logic [DIV_W-1:0] div_q;
  logic             rise_next;
  logic             ovf_clr;
  logic             res_valid;
  logic [SEL_W-1:0] res_chan;
  logic [RES_W-1:0] res_data;

  assign ovf_clr = cfg_we && !cfg_wdata[CFG_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      last_q <= '0;
      div_q  <= '0;
    end else if (cfg_we) begin
      en_q   <= cfg_wdata[CFG_EN_BIT];
      dma_q  <= cfg_wdata[CFG_DMA_BIT];
      last_q <= cfg_wdata[SEL_W-1:0];
      div_q  <= cfg_wdata[CFG_DIV_LSB +: DIV_W];
    end
  end

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(en_q), .div(div_q),
    .adc_clk(adc_clk), .rise_next(rise_next)
  );

  adc_scan_fsm #(.SEL_W(SEL_W), .RES_W(RES_W)) u_fsm (
    .clk(clk), .rst(rst), .run(en_q), .last_chan(last_q),
    .rise_next(rise_next), .adc_done(adc_done), .adc_dout(adc_dout),
    .adc_rst(adc_rst), .adc_start(adc_start), .adc_sel(adc_sel),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
  );

  adc_result_sink #(.NCH(NCH), .SEL_W(SEL_W), .RES_W(RES_W)) u_sink (
    .clk(clk), .rst(rst), .dma_mode(dma_q), .ovf_clr(ovf_clr),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .rd_chan(rd_chan), .rd_data(rd_data),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_data(dma_data),
    .ovf_flag(ovf_flag)
  );

  adc_len_check #(.LEN_W(LEN_W), .SEL_W(SEL_W)) u_len (
    .clk(clk), .rst(rst), .len_we(len_we), .len_words(len_words),
    .last_chan(last_q), .len_err(len_err)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic             adc_clk,
  input logic             adc_rst,
  input logic             adc_start,
  input logic [SEL_W-1:0] adc_sel,
  input logic             dma_valid,
  input logic             dma_ready,
  input logic [31:0]      dma_data,
  input logic             ovf_flag
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    adc_rst |-> (!adc_start && !adc_clk));

  p_start_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_start) |-> $rose(adc_clk));

  p_start_fall_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_start) && !adc_rst) |-> $rose(adc_clk));

  p_sel_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (adc_start && $past(adc_start)) |-> $stable(adc_sel));

  p_sel_home_r5: assert property (@(posedge clk) disable iff (rst)
    adc_rst |-> (adc_sel == '0));

  p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_data)));

  p_word_zeros_r6: assert property (@(posedge clk) disable iff (rst)
    dma_valid |-> (dma_data[31:19] == '0 && dma_data[15:12] == '0));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(cfg_we && !cfg_wdata[31])) |=> ovf_flag);

  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_wdata[31]) |=> !ovf_flag);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .adc_clk(adc_clk), .adc_rst(adc_rst), .adc_start(adc_start),
  .adc_sel(adc_sel), .dma_valid(dma_valid), .dma_ready(dma_ready),
  .dma_data(dma_data), .ovf_flag(ovf_flag)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        len_we = 1'b0;
  logic [15:0] len_words = '0;
  logic [2:0]  rd_chan = '0;
  logic [31:0] rd_data;
  logic        adc_clk, adc_rst, adc_start;
  logic [2:0]  adc_sel;
  logic        adc_done = 1'b0;
  logic [11:0] adc_dout = '0;
  logic        dma_valid;
  logic        dma_ready = 1'b1;
  logic [31:0] dma_data;
  logic        ovf_flag, len_err;

  always #5 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .len_we(len_we), .len_words(len_words), .rd_chan(rd_chan),
    .rd_data(rd_data), .adc_clk(adc_clk), .adc_rst(adc_rst),
    .adc_start(adc_start), .adc_sel(adc_sel), .adc_done(adc_done),
    .adc_dout(adc_dout), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .ovf_flag(ovf_flag), .len_err(len_err)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expw(input int ch, input int num);
    return {13'b0, 3'(ch), 4'b0, 3'(ch), 1'b0, 8'(num)};
  endfunction

  // converter model: done three cycles after start falls
  int   cnum = 0;
  int   last_num [8];
  bit   bench_en = 0;
  int   dly = 0;
  logic prev_start = 1'b0;

  always @(posedge clk) begin
    if (rst || adc_rst || !bench_en) begin
      dly      <= 0;
      adc_done <= 1'b0;
    end else begin
      adc_done <= 1'b0;
      if (prev_start && !adc_start) dly <= 3;
      else if (dly > 1) dly <= dly - 1;
      else if (dly == 1) begin
        dly      <= 0;
        adc_done <= 1'b1;
        adc_dout <= {adc_sel, 1'b0, 8'(cnum)};
        last_num[adc_sel] = cnum;
        cnum = cnum + 1;
      end
    end
    prev_start <= adc_start;
  end

  // monitors for start width, select stability and stream activity
  int       st_len = 0, start_bad = 0, sel_bad = 0, start_cnt = 0, cur_div = 0;
  bit       busy = 0, valid_seen = 0;
  logic [2:0] busy_sel = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (adc_start) st_len++;
      else if (st_len != 0) begin
        if (!adc_rst && st_len != 2 * (cur_div + 1)) start_bad++;
        st_len = 0;
        start_cnt++;
      end
      if (adc_rst) busy = 0;
      else if (adc_start && !busy) begin busy = 1; busy_sel = adc_sel; end
      else if (busy && adc_done) busy = 0;
      else if (busy && adc_sel != busy_sel) sel_bad++;
      if (dma_valid) valid_seen = 1;
    end
  end

  task automatic cfg_write(input bit en, input bit dma, input int cnt, input int dv);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {en, 7'b0, 8'(dv), 12'b0, dma, 3'(cnt)};
    bench_en  = en;
    cur_div   = dv;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic len_write(input int len);
    @(negedge clk);
    len_we = 1'b1;
    len_words = 16'(len);
    @(negedge clk);
    len_we = 1'b0;
  endtask

  task automatic get_word(output logic [31:0] w);
    do @(negedge clk); while (!(dma_valid && dma_ready));
    w = dma_data;
  endtask

  task automatic measure_period(output int p);
    logic prev;
    bit   armed;
    prev = adc_clk; armed = 0; p = 0;
    forever begin
      @(negedge clk);
      if (armed) p++;
      if (!prev && adc_clk) begin
        if (armed) break;
        armed = 1; p = 0;
      end
      prev = adc_clk;
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    summary();
  end

  localparam int NV = 4;
  localparam int V_CNT [NV] = '{0, 2, 7, 3};
  localparam int V_DIV [NV] = '{0, 1, 3, 2};
  localparam int V_LEN [NV] = '{5, 12, 16, 10};
  localparam int V_ERR [NV] = '{0, 0, 0, 1};

  initial begin
    logic [31:0] w;
    int p, n0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(adc_rst == 1'b1,   "R1 reset adc_rst", 32'(adc_rst), 1);
    chk(adc_start == 1'b0, "R1 reset adc_start", 32'(adc_start), 0);
    chk(adc_clk == 1'b0,   "R1 reset adc_clk", 32'(adc_clk), 0);
    chk(dma_valid == 1'b0, "R8 reset dma_valid", 32'(dma_valid), 0);
    chk(ovf_flag == 1'b0,  "R9 reset ovf_flag", 32'(ovf_flag), 0);
    chk(len_err == 1'b1,   "R11 zero length", 32'(len_err), 1);

    // R1: fields written with enable 0 start nothing
    cfg_write(0, 1, 2, 1);
    repeat (40) @(negedge clk);
    chk(start_cnt == 0, "R1 no start while disabled", 32'(start_cnt), 0);
    chk(adc_rst == 1'b1, "R1 reset held while disabled", 32'(adc_rst), 1);
    chk(adc_clk == 1'b0, "R1 clock idle while disabled", 32'(adc_clk), 0);

    // vector table: stream mode scans, length check and clock period
    for (int v = 0; v < NV; v++) begin
      cfg_write(0, 1, V_CNT[v], V_DIV[v]);
      len_write(V_LEN[v]);
      repeat (2) @(negedge clk);
      chk(len_err == V_ERR[v][0], "R11 length check", 32'(len_err), 32'(V_ERR[v]));
      cfg_write(1, 1, V_CNT[v], V_DIV[v]);
      for (int i = 0; i < 2 * (V_CNT[v] + 1) + 1; i++) begin
        get_word(w);
        chk(w[18:16] == 3'(i % (V_CNT[v] + 1)), "R5 R8 scan order", 32'(w[18:16]),
            32'(i % (V_CNT[v] + 1)));
        chk(w == expw(w[18:16], last_num[w[18:16]]), "R6 word format", w,
            expw(w[18:16], last_num[w[18:16]]));
      end
      measure_period(p);
      chk(p == 2 * (V_DIV[v] + 1), "R2 adc_clk period", 32'(p), 32'(2 * (V_DIV[v] + 1)));
      cfg_write(0, 1, V_CNT[v], V_DIV[v]);
      repeat (10) @(negedge clk);
    end

    // R7: register mode
    valid_seen = 0;
    n0 = cnum;
    cfg_write(1, 0, 3, 1);
    while (cnum < n0 + 9) @(negedge clk);
    repeat (3) @(negedge clk);
    cfg_write(0, 0, 3, 1);
    repeat (4) @(negedge clk);
    chk(valid_seen == 0, "R7 no stream output in register mode", 32'(valid_seen), 0);
    for (int ch = 0; ch < 4; ch++) begin
      @(negedge clk) rd_chan = 3'(ch);
      @(negedge clk);
      chk(rd_data == expw(ch, last_num[ch]), "R7 channel register read", rd_data,
          expw(ch, last_num[ch]));
    end

    // R9: overflow with stalled sink
    cfg_write(0, 1, 0, 0);
    dma_ready = 1'b0;
    repeat (5) @(negedge clk);
    n0 = cnum;
    cfg_write(1, 1, 0, 0);
    while (cnum < n0 + 2) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ovf_flag == 1'b1, "R9 overflow set", 32'(ovf_flag), 1);
    chk(dma_valid == 1'b1, "R9 pending word kept", 32'(dma_valid), 1);
    chk(dma_data == expw(0, n0), "R9 first word kept, later dropped", dma_data, expw(0, n0));
    repeat (6) @(negedge clk);
    chk(ovf_flag == 1'b1, "R9 overflow sticky", 32'(ovf_flag), 1);

    // R10: clearing enable clears overflow, restart at channel 0
    cfg_write(0, 1, 0, 0);
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R10 overflow cleared", 32'(ovf_flag), 0);
    chk(dma_data == expw(0, n0), "R8 word held while not ready", dma_data, expw(0, n0));
    dma_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dma_valid == 1'b0, "R8 word accepted", 32'(dma_valid), 0);
    cfg_write(1, 1, 2, 0);
    get_word(w);
    chk(w[18:16] == 3'd0, "R10 restart at channel 0", 32'(w[18:16]), 0);
    get_word(w);
    chk(w[18:16] == 3'd1, "R10 next channel 1", 32'(w[18:16]), 1);
    chk(ovf_flag == 1'b0, "R10 no overflow after restart", 32'(ovf_flag), 0);
    cfg_write(0, 1, 2, 0);
    repeat (5) @(negedge clk);

    chk(start_cnt > 10, "R3 start pulses seen", 32'(start_cnt), 11);
    chk(start_bad == 0, "R3 start width", 32'(start_bad), 0);
    chk(sel_bad == 0, "R4 select stable", 32'(sel_bad), 0);
    summary();
  end
endmodule